// File: doc/BRIEF.md
# Fractional Multiplier Unit

This block is the multiply stage of a small 8-bit processor datapath. It takes two register operands and a three-bit operation code, multiplies them as unsigned, signed, or signed-by-unsigned numbers, and can optionally apply a fractional (Q-format) left shift of one bit to the product. The 16-bit result always goes to one fixed destination register pair, split here into a high byte and a low byte. The register file and decoder upstream do not need to steer the result.

Only two status bits change. Carry and zero are written into a copy of the status byte, and every other status bit passes through unchanged from the value presented with the request. A start/done handshake gives a fixed two-cycle latency. The unit accepts a new request every second cycle, and ignores a request that arrives while it is busy.

The operand width and the multiplier structure are parameters. The structure is either an inferred multiplier or an explicit shift-add array of partial products.

Top module: `fmul_unit`

## Requirements
- R1: `op_i[1:0]` selects signedness: 00 unsigned×unsigned, 01 signed×signed, 10 signed first operand × unsigned second operand (first operand sign-extended, second zero-extended), 11 behaves as unsigned×unsigned. `op_i[2]`=1 selects the fractional form.
- R2: In non-fractional forms `{prod_hi_o, prod_lo_o}` equals the low 16 bits of the two's-complement product of the extended operands.
- R3: In fractional forms the result is that product shifted left by one bit, truncated to 16 bits.
- R4: `sreg_o[0]` (carry) equals bit 15 of the product before any fractional shift.
- R5: `sreg_o[1]` (zero) is 1 exactly when the final 16-bit result is all zeros.
- R6: `sreg_o[7:2]` equal `sreg_i[7:2]` as sampled on the edge that accepted the request. Later changes of `sreg_i` have no effect on them.
- R7: A request is accepted on a rising edge where `start_i`=1 and `busy_o`=0. `busy_o` is high for the following cycle. `done_o` is high for exactly the cycle after the next edge, and the new result is valid in that same cycle.
- R8: A `start_i` seen while `busy_o`=1 is ignored. It produces no second `done_o` pulse and no change of the result.
- R9: Between `done_o` pulses, `prod_hi_o`, `prod_lo_o` and `sreg_o` hold their last values whatever the inputs do.
- R10: While `rst_n`=0, and after release until the first result, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code: [1:0] signedness, [2] fractional |
| opa_i | input | W | First operand |
| opb_i | input | W | Second operand |
| sreg_i | input | SR_W | Status byte presented with the request |
| busy_o | output | 1 | High in the cycle after a request is accepted |
| done_o | output | 1 | One-cycle result strobe |
| prod_hi_o | output | W | High half of the result register pair |
| prod_lo_o | output | W | Low half of the result register pair |
| sreg_o | output | SR_W | Status byte with carry (bit 0) and zero (bit 1) updated |

## Verification
The bench builds the unit at its 8-bit width with the shift-add array variant. This puts the generated partial-product rows and the final subtraction of the sign row under test.

For all eight operation codes it sweeps every first-operand value against twenty second-operand values. These include 0x00, 0x01, 0x7F, 0x80, 0x81 and 0xFF, so the sign boundaries are reached in each signedness mode. Examples are -128×-128, the overflow of the fractional shift, and the carry taken before that shift.

Dedicated sequences cover a request held high during the busy cycle, long idle stretches with moving inputs, and the reset values.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

   // signedness selection carried in the low bits of the operation code
   typedef enum logic [1:0] {
      SGN_UU  = 2'b00,
      SGN_SS  = 2'b01,
      SGN_SU  = 2'b10,
      SGN_RSV = 2'b11
   } sgn_mode_e;

   localparam int OP_W     = 3;
   localparam int FRAC_BIT = 2;

   // status byte positions decoded by the neighbouring flag logic
   localparam int FLAG_C = 0;
   localparam int FLAG_Z = 1;

   // multiplier structure variants
   localparam int STYLE_INFER = 0;
   localparam int STYLE_ARRAY = 1;

endpackage

// File: rtl/fmul_operand_ext.sv
module fmul_operand_ext
   import fmul_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0]      a_i,
   input  logic [W-1:0]      b_i,
   input  sgn_mode_e         mode_i,
   output logic signed [W:0] a_o,
   output logic signed [W:0] b_o
);

   logic a_signed;
   logic b_signed;

   always_comb begin
      a_signed = (mode_i == SGN_SS) || (mode_i == SGN_SU);
      b_signed = (mode_i == SGN_SS);
      a_o = a_signed ? {a_i[W-1], a_i} : {1'b0, a_i};
      b_o = b_signed ? {b_i[W-1], b_i} : {1'b0, b_i};
   end

endmodule

// File: rtl/fmul_core.sv
module fmul_core
   import fmul_pkg::*;
#(
   parameter int W     = 8,
   parameter int STYLE = STYLE_INFER
) (
   input  logic signed [W:0] a_i,
   input  logic signed [W:0] b_i,
   output logic [2*W-1:0]    prod_o
);

   localparam int PW = 2 * W + 2;

   logic [PW-1:0] full;
   logic [PW-1:0] a_x;
   logic [PW-1:0] b_x;

   assign a_x = {{(PW-W-1){a_i[W]}}, a_i};
   assign b_x = {{(PW-W-1){b_i[W]}}, b_i};

   if (STYLE == STYLE_INFER) begin : g_infer
      assign full = $signed(a_x) * $signed(b_x);
   end else begin : g_array
      logic [PW-1:0] acc [W+2];
      assign acc[0] = '0;
      for (genvar i = 0; i < W; i++) begin : g_row
         assign acc[i+1] = acc[i] + (b_i[i] ? (a_x << i) : '0);
      end
      // sign row carries negative weight
      assign acc[W+1] = acc[W] - (b_i[W] ? (a_x << W) : '0);
      assign full = acc[W+1];
   end

   assign prod_o = full[2*W-1:0];

   // extended operands always yield a product that fits in 2W+1 signed bits
   always_comb begin
      p_fit_r2: assert ($isunknown(full) || (full[PW-1] == full[2*W]))
         else $error("product exceeds signed range");
   end

endmodule

// File: rtl/fmul_result.sv
module fmul_result #(
   parameter int W = 8
) (
   input  logic [2*W-1:0] raw_i,
   input  logic           frac_i,
   output logic [2*W-1:0] res_o,
   output logic           z_o,
   output logic           c_o
);

   always_comb begin
      c_o   = raw_i[2*W-1];
      res_o = frac_i ? {raw_i[2*W-2:0], 1'b0} : raw_i;
      z_o   = (res_o == '0);
   end

endmodule

// File: rtl/fmul_unit.sv
module fmul_unit
   import fmul_pkg::*;
#(
   parameter int W          = 8,
   parameter int MULT_STYLE = STYLE_INFER,
   parameter int SR_W       = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [OP_W-1:0] op_i,
   input  logic [W-1:0]    opa_i,
   input  logic [W-1:0]    opb_i,
   input  logic [SR_W-1:0] sreg_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [W-1:0]    prod_hi_o,
   output logic [W-1:0]    prod_lo_o,
   output logic [SR_W-1:0] sreg_o
);

   localparam int RW = 2 * W;

   if (W < 2) begin : g_bad_w
      $error("fmul_unit: W must be at least 2");
   end
   if (MULT_STYLE != STYLE_INFER && MULT_STYLE != STYLE_ARRAY) begin : g_bad_style
      $error("fmul_unit: unknown MULT_STYLE");
   end
   if (SR_W < 2) begin : g_bad_sr
      $error("fmul_unit: status byte too narrow for carry and zero");
   end

   logic signed [W:0] a_ext, b_ext;
   logic signed [W:0] a_q, b_q;
   logic              frac_q;
   logic              stg_v;
   logic              done_q;
   logic [SR_W-1:0]   keep_q;
   logic [SR_W-1:0]   sreg_q;
   logic [RW-1:0]     res_q;
   logic [RW-1:0]     raw;
   logic [RW-1:0]     res;
   logic              z_flag, c_flag;
   logic              accept;
   logic [SR_W-1:0]   sreg_nxt;

   fmul_operand_ext #(.W(W)) u_ext (
      .a_i    (opa_i),
      .b_i    (opb_i),
      .mode_i (sgn_mode_e'(op_i[1:0])),
      .a_o    (a_ext),
      .b_o    (b_ext)
   );

   fmul_core #(.W(W), .STYLE(MULT_STYLE)) u_core (
      .a_i    (a_q),
      .b_i    (b_q),
      .prod_o (raw)
   );

   fmul_result #(.W(W)) u_res (
      .raw_i  (raw),
      .frac_i (frac_q),
      .res_o  (res),
      .z_o    (z_flag),
      .c_o    (c_flag)
   );

   assign accept = start_i && !stg_v;

   always_comb begin
      sreg_nxt         = keep_q;
      sreg_nxt[FLAG_C] = c_flag;
      sreg_nxt[FLAG_Z] = z_flag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_v  <= 1'b0;
         done_q <= 1'b0;
         a_q    <= '0;
         b_q    <= '0;
         frac_q <= 1'b0;
         keep_q <= '0;
         res_q  <= '0;
         sreg_q <= '0;
      end else begin
         stg_v  <= accept;
         done_q <= stg_v;
         if (accept) begin
            a_q    <= a_ext;
            b_q    <= b_ext;
            frac_q <= op_i[FRAC_BIT];
            keep_q <= sreg_i;
         end
         if (stg_v) begin
            res_q  <= res;
            sreg_q <= sreg_nxt;
         end
      end
   end

   assign busy_o    = stg_v;
   assign done_o    = done_q;
   assign prod_hi_o = res_q[RW-1:W];
   assign prod_lo_o = res_q[W-1:0];
   assign sreg_o    = sreg_q;

   p_start_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !done_o))
      else $error("accepted request did not raise busy");

   p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> done_o)
      else $error("done missing after busy cycle");

   p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o)
      else $error("done wider than one cycle");

   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> !busy_o)
      else $error("request during busy was accepted");

   p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (sreg_o[SR_W-1:2] == $past(sreg_i[SR_W-1:2], 2)))
      else $error("untouched status bits changed");

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable({prod_hi_o, prod_lo_o, sreg_o}))
      else $error("result moved without done");

endmodule

// File: tb/tb_fmul_unit.sv
`timescale 1ns/1ps
module tb_fmul_unit;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [2:0]   op_i = '0;
   logic [W-1:0] opa_i = '0;
   logic [W-1:0] opb_i = '0;
   logic [7:0]   sreg_i = '0;
   logic         busy_o, done_o;
   logic [W-1:0] prod_hi_o, prod_lo_o;
   logic [7:0]   sreg_o;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   fmul_unit #(.W(W), .MULT_STYLE(1), .SR_W(8)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .op_i      (op_i),
      .opa_i     (opa_i),
      .opb_i     (opb_i),
      .sreg_i    (sreg_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .prod_hi_o (prod_hi_o),
      .prod_lo_o (prod_lo_o),
      .sreg_o    (sreg_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic int bval(input int j);
      case (j)
         16: return 1;
         17: return 127;
         18: return 128;
         19: return 129;
         default: return j * 17;
      endcase
   endfunction

   // raw 16-bit product before any fractional shift
   function automatic int model_raw(input int a, input int b, input int op);
      int ax = a;
      int bx = b;
      int m  = op & 3;
      if ((m == 1 || m == 2) && a >= 128) ax = a - 256;
      if (m == 1 && b >= 128) bx = b - 256;
      return (ax * bx) & 16'hFFFF;
   endfunction

   // called at a falling edge; returns at the falling edge where done is high
   task automatic do_op(input int a, input int b, input int op, input int sr);
      int raw, res, m;
      start_i = 1'b1;
      opa_i   = 8'(a);
      opb_i   = 8'(b);
      op_i    = 3'(op);
      sreg_i  = 8'(sr);
      @(negedge clk);
      check("R7 busy after accept", {30'd0, busy_o, done_o}, 32'b10);
      start_i = 1'b0;
      opa_i   = ~8'(a);
      opb_i   = 8'(b) ^ 8'h5A;
      sreg_i  = ~8'(sr);
      @(negedge clk);
      raw = model_raw(a, b, op);
      res = (op & 4) != 0 ? (raw << 1) & 16'hFFFF : raw;
      m   = op & 3;
      check("R7 done pulse", {31'd0, done_o}, 32'd1);
      if (m == 3)
         check("R1 reserved code as unsigned", {16'd0, prod_hi_o, prod_lo_o}, 32'(res));
      else if ((op & 4) != 0)
         check("R3 fractional product", {16'd0, prod_hi_o, prod_lo_o}, 32'(res));
      else
         check("R2 product", {16'd0, prod_hi_o, prod_lo_o}, 32'(res));
      check("R4 carry", {31'd0, sreg_o[0]}, 32'((raw >> 15) & 1));
      check("R5 zero", {31'd0, sreg_o[1]}, (res == 0) ? 32'd1 : 32'd0);
      check("R6 kept status bits", {26'd0, sreg_o[7:2]}, 32'((sr >> 2) & 63));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] held;
      logic [7:0]  held_sr;
      repeat (3) @(negedge clk);
      check("R10 reset outputs", {12'd0, busy_o, done_o, prod_hi_o, prod_lo_o, sreg_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R10 outputs after release", {12'd0, busy_o, done_o, prod_hi_o, prod_lo_o, sreg_o}, 32'd0);

      // corner cases first
      do_op(8'h80, 8'h80, 1, 8'hFC);  // -128*-128 = 0x4000
      do_op(8'h80, 8'h80, 5, 8'h00);  // fractional: 0x8000, carry 0
      do_op(8'hFF, 8'hFF, 2, 8'hA5);  // -1*255 = 0xFF01
      do_op(8'hFF, 8'hFF, 4, 8'h03);  // 0xFE01<<1, carry 1
      do_op(8'h00, 8'h37, 6, 8'hFF);  // zero result

      // sweep
      for (int op = 0; op < 8; op++) begin
         for (int bi = 0; bi < 20; bi++) begin
            for (int a = 0; a < 256; a++) begin
               do_op(a, bval(bi), op, (a * 7 + bi * 13) & 255);
            end
         end
      end

      // R8: request held high across the busy cycle
      start_i = 1'b1; opa_i = 8'h12; opb_i = 8'h34; op_i = 3'd0; sreg_i = 8'h00;
      @(negedge clk);
      check("R8 busy with start held", {31'd0, busy_o}, 32'd1);
      opa_i = 8'hFF; opb_i = 8'hFF; op_i = 3'd1;
      @(negedge clk);
      check("R8 first result done", {31'd0, done_o}, 32'd1);
      check("R8 first result value", {16'd0, prod_hi_o, prod_lo_o}, 32'h03A8);
      start_i = 1'b0;
      @(negedge clk);
      check("R8 no second done", {30'd0, done_o, busy_o}, 32'd0);
      check("R8 result unchanged", {16'd0, prod_hi_o, prod_lo_o}, 32'h03A8);

      // R9: idle with moving inputs
      held    = {prod_hi_o, prod_lo_o};
      held_sr = sreg_o;
      for (int k = 0; k < 8; k++) begin
         opa_i = 8'(k * 31); opb_i = 8'(k * 53); op_i = 3'(k); sreg_i = 8'(k * 19);
         @(negedge clk);
         check("R9 product held", {16'd0, prod_hi_o, prod_lo_o}, {16'd0, held});
         check("R9 status held", {24'd0, sreg_o}, {24'd0, held_sr});
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule